// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs clause-22 management transactions toward PHY devices over a two-wire management bus. Software composes a complete 32-bit management frame word (start code, opcode, PHY address, register address, turnaround and data) and writes it into the data register. The block then clocks a 32-bit preamble of ones followed by that word onto the data line, one bit per management clock period. For read opcodes it releases the data line through the turnaround and data phases. It shifts the returned 16 bits into the low half of the same data register.

When the last bit has gone out, an event bit is raised in the event register, and software clears it by writing a one to it. A speed register sets the management clock rate. The high and low phases of the management clock each last "speed field" system clock cycles. Software therefore programs the field as the system frequency divided by 5 MHz, rounded up, which keeps the management clock at or below 2.5 MHz. The field sits one bit up in the register, so the register value is the field shifted left by one.

Register offsets on the word-addressed bus: 0 = frame data, 1 = speed, 2 = event. Reads are combinational from the current address.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After a write to the data register (offset 0) while idle, the data line carries 32 ones followed by the 32-bit word, most significant bit first, one bit per management clock period. The word layout is: bits 31:30 start 01, bits 29:28 opcode (10 read, 01 write), bits 27:23 PHY address, bits 22:18 register address, bits 17:16 turnaround 10, bits 15:0 data.
- R2: The data output and its output enable change only when the management clock falls; both are stable while it is high.
- R3: With speed field F = speed register bits 6:1 (register offset 1) and F nonzero, the management clock stays high for F system cycles and low for F system cycles. It rests low when no frame is in progress.
- R4: Counting bits from 0 for the first preamble bit, a read frame (opcode 10) releases the output enable from bit 47 (the second turnaround bit) through bit 63. A write frame drives all 64 bits, and the line is released while idle.
- R5: After a read frame, data register bits 15:0 hold the 16 bits sampled on the rising clock edges of bits 48 to 63, first bit most significant. Bits 31:16 keep the command.
- R6: A read from an address with no device returns 0xFFFF, because the line is pulled high.
- R7: At the end of every frame, bit 23 of the event register (offset 2) becomes 1.
- R8: Writing a word with bit 23 set to the event register clears the event bit; writing a word with bit 23 clear leaves it unchanged.
- R9: A write to the data register while a frame is in progress is ignored: the register and the frame on the line are unchanged.
- R10: A speed field of 0 holds the management clock still. A frame started or in progress stalls and resumes once a nonzero field is written.
- R11: After reset the management clock is low, the line is released, the event bit is 0 and the data register reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output value |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data line as seen at the pad |

## Verification
The checker watches several properties on every cycle. It confirms that the data output and its enable are frozen while the management clock is high, and that the enable is low whenever no frame runs. It also checks that each frame end raises the event bit, that a write-one clears it, that busy-time data writes leave the register untouched, and that a zero speed field freezes the clock. Several behaviours are shown only by the bench scenarios: the exact 64-bit line content of read and write frames, and the enable pattern bit by bit. The bench also covers the captured PHY reply, including the all-ones result with no device, the measured clock high time for two speed settings, and a frame stalled by a zero speed and then resumed.

// File: rtl/mdio_mgmt_pkg.sv
`timescale 1ns/1ps
// Package: register offsets and frame geometry shared by the
// management master, its submodules and its checker.
package mdio_mgmt_pkg;
    localparam int ADDR_W     = 2;
    localparam int REG_W      = 32;
    localparam int PRE_BITS   = 32;
    localparam int FRM_BITS   = 32;
    localparam int DAT_BITS   = 16;
    localparam int EVT_BIT    = 23;
    localparam logic [ADDR_W-1:0] OFS_DATA  = 2'd0;
    localparam logic [ADDR_W-1:0] OFS_SPEED = 2'd1;
    localparam logic [ADDR_W-1:0] OFS_EVENT = 2'd2;
    localparam logic [1:0] OPC_READ = 2'b10;
endpackage

// File: rtl/mdio_clk_div.sv
`timescale 1ns/1ps
// Module: management clock generator.
// Produces mdc with F cycles high and F cycles low while run is set.
// Assumes: div == 0 freezes the clock in its current phase; mdc is
// forced low and the counter cleared whenever run is low.
// rise_p / fall_p mark the cycle whose edge flips mdc up / down.
module mdio_clk_div #(
    parameter int SPD_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SPD_W-1:0] div,
    output logic             mdc,
    output logic             rise_p,
    output logic             fall_p
);
    logic [SPD_W-1:0] cnt;
    logic             term;

    // Purpose: detect the last system cycle of the current phase.
    always_comb begin
        term   = run && (div != '0) && (cnt == div - 1'b1);
        rise_p = term && !mdc;
        fall_p = term && mdc;
    end

    // Purpose: count system cycles within a phase and toggle mdc.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (div != '0) begin
            if (term) begin
                cnt <= '0;
                mdc <= ~mdc;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mdio_frame_shift.sv
`timescale 1ns/1ps
// Module: preamble plus frame shifter with read-data capture.
// Loads all-ones preamble and the frame word on start, advances one
// bit per fall_p, samples the line on rise_p during read data bits.
// Assumes: start is only asserted while busy is low.
module mdio_frame_shift #(
    parameter int PRE_BITS = 32,
    parameter int FRM_BITS = 32,
    parameter int DAT_BITS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [FRM_BITS-1:0] word,
    input  logic                rise_p,
    input  logic                fall_p,
    input  logic                mdio_i,
    output logic                busy,
    output logic                done,
    output logic                is_read,
    output logic                mdio_o,
    output logic                mdio_oe,
    output logic [DAT_BITS-1:0] rd_data
);
    import mdio_mgmt_pkg::*;

    localparam int TOT    = PRE_BITS + FRM_BITS;
    localparam int IDX_W  = $clog2(TOT + 1);
    localparam int DSTART = TOT - DAT_BITS;
    localparam int TA2    = DSTART - 1;
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(TOT - 1);
    localparam logic [IDX_W-1:0] TA2_IDX   = IDX_W'(TA2);
    localparam logic [IDX_W-1:0] DATA_IDX  = IDX_W'(DSTART);

    logic [TOT-1:0]      sr;
    logic [IDX_W-1:0]    idx;
    logic                rd_op;
    logic [DAT_BITS-1:0] cap;

    // Purpose: drive the line and report completion from frame state.
    always_comb begin
        mdio_o  = busy ? sr[TOT-1] : 1'b1;
        mdio_oe = busy && !(rd_op && (idx >= TA2_IDX));
        done    = busy && fall_p && (idx == LAST_IDX);
        is_read = rd_op;
        rd_data = cap;
    end

    // Purpose: load, shift and finish the frame; capture read bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            sr    <= '1;
            idx   <= '0;
            rd_op <= 1'b0;
            cap   <= '0;
        end else if (!busy) begin
            if (start) begin
                busy  <= 1'b1;
                sr    <= {{PRE_BITS{1'b1}}, word};
                idx   <= '0;
                rd_op <= (word[FRM_BITS-3 -: 2] == OPC_READ);
            end
        end else begin
            if (rise_p && rd_op && (idx >= DATA_IDX))
                cap <= {cap[DAT_BITS-2:0], mdio_i};
            if (fall_p) begin
                if (idx == LAST_IDX) begin
                    busy <= 1'b0;
                end else begin
                    idx <= idx + 1'b1;
                    sr  <= {sr[TOT-2:0], 1'b1};
                end
            end
        end
    end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
// Module: management frame master with three word registers.
// Offset 0 holds the frame word (read reply lands in bits 15:0),
// offset 1 holds the speed field in bits SPD_W:1, offset 2 holds
// the completion event in bit 23 (write one to clear).
// Assumes: a single-cycle write strobe; reads are combinational.
module mdio_mgmt_ctrl #(
    parameter int SPD_W = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    import mdio_mgmt_pkg::*;

    logic [REG_W-1:0]    data_q;
    logic [SPD_W-1:0]    spd_field;
    logic                evt_q;
    logic                frame_busy;
    logic                frame_done;
    logic                frame_rd;
    logic [DAT_BITS-1:0] reply;
    logic                rise_p;
    logic                fall_p;
    logic                start;

    // Purpose: a data write launches a frame only while idle.
    always_comb start = bus_wr && (bus_addr == OFS_DATA) && !frame_busy;

    mdio_clk_div #(.SPD_W(SPD_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (frame_busy),
        .div    (spd_field),
        .mdc    (mdc),
        .rise_p (rise_p),
        .fall_p (fall_p)
    );

    mdio_frame_shift #(
        .PRE_BITS (PRE_BITS),
        .FRM_BITS (FRM_BITS),
        .DAT_BITS (DAT_BITS)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .word    (bus_wdata),
        .rise_p  (rise_p),
        .fall_p  (fall_p),
        .mdio_i  (mdio_i),
        .busy    (frame_busy),
        .done    (frame_done),
        .is_read (frame_rd),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .rd_data (reply)
    );

    // Purpose: frame word register, updated on launch and read completion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (start)
            data_q <= bus_wdata;
        else if (frame_done && frame_rd)
            data_q[DAT_BITS-1:0] <= reply;
    end

    // Purpose: speed field register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            spd_field <= '0;
        else if (bus_wr && (bus_addr == OFS_SPEED))
            spd_field <= bus_wdata[SPD_W:1];
    end

    // Purpose: completion event, set wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            evt_q <= 1'b0;
        else if (frame_done)
            evt_q <= 1'b1;
        else if (bus_wr && (bus_addr == OFS_EVENT) && bus_wdata[EVT_BIT])
            evt_q <= 1'b0;
    end

    // Purpose: register read mux.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_DATA:  bus_rdata = data_q;
            OFS_SPEED: bus_rdata[SPD_W:1] = spd_field;
            OFS_EVENT: bus_rdata[EVT_BIT] = evt_q;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mdio_mgmt_checks.sv
`timescale 1ns/1ps
// Module: property checker for mdio_mgmt_ctrl, attached by bind.
module mdio_mgmt_checks #(
    parameter int SPD_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mdc,
    input logic             mdio_o,
    input logic             mdio_oe,
    input logic             busy,
    input logic             done,
    input logic             evt_q,
    input logic [SPD_W-1:0] spd_field,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic             clr_bit,
    input logic [31:0]      data_q
);
    import mdio_mgmt_pkg::*;

    assert_line_frozen_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    assert_idle_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);

    assert_event_on_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> evt_q);

    assert_event_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == OFS_EVENT) && clr_bit && !done) |=> !evt_q);

    assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr && (bus_addr == OFS_DATA) && !done) |=> $stable(data_q));

    assert_zero_speed_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (spd_field == '0)) |=> $stable(mdc));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_checks #(.SPD_W(SPD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .busy      (frame_busy),
    .done      (frame_done),
    .evt_q     (evt_q),
    .spd_field (spd_field),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .clr_bit   (bus_wdata[23]),
    .data_q    (data_q)
);

// File: tb/sim_mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module sim_mdio_mgmt_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int checks = 0;
    int errors = 0;

    // PHY model state
    bit          phy_en = 0;
    bit          cur_rd = 0;
    logic [15:0] phy_reply = '0;
    logic        phy_drv = 1'b0;
    logic        phy_val = 1'b1;
    int          fall_cnt = 0;

    typedef struct {
        logic [63:0] line;
        bit          rd;
    } item_t;
    item_t exp_q[$];

    logic [63:0] cap_line = '0;
    int          bitpos = 0;
    bit          oe_bad = 0;
    logic        held_o = 1'b1;
    logic        held_oe = 1'b0;
    bit          held_ok = 0;
    bit          r2_bad = 0;
    longint      t_rise = 0;
    longint      high_ns = 0;

    always #5 clk = ~clk;

    // line resolution: design, PHY, or pull-up
    assign mdio_i = mdio_oe ? mdio_o : (phy_drv ? phy_val : 1'b1);

    mdio_mgmt_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_event();
        logic [31:0] v;
        for (int i = 0; i < 20000; i++) begin
            reg_read(2'd2, v);
            if (v[23]) return;
        end
    endtask

    function automatic logic [31:0] mk_word(input bit rd, input logic [4:0] pa,
                                            input logic [4:0] ra, input logic [15:0] d);
        return {2'b01, (rd ? 2'b10 : 2'b01), pa, ra, 2'b10, d};
    endfunction

    // Driver: push expected line, launch frame, check reply and event.
    task automatic run_frame(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                             input logic [15:0] d, input bit present,
                             input logic [15:0] reply, input string tag);
        item_t it;
        logic [31:0] w, v, expd;
        logic [15:0] got;
        w = mk_word(rd, pa, ra, d);
        got = present ? reply : 16'hFFFF;
        it.rd = rd;
        if (rd) it.line = {32'hFFFF_FFFF, w[31:17], (present ? 1'b0 : 1'b1), got};
        else    it.line = {32'hFFFF_FFFF, w};
        exp_q.push_back(it);
        phy_en = present; cur_rd = rd; phy_reply = reply; fall_cnt = 0;
        reg_write(2'd0, w);
        wait_event();
        reg_read(2'd2, v);
        check(v[23] === 1'b1, {"R7 event set ", tag}, 64'(v), 64'(32'h0080_0000));
        reg_read(2'd0, v);
        expd = rd ? {w[31:16], got} : w;
        check(v === expd, rd ? (present ? {"R5 reply ", tag} : {"R6 no device ", tag})
                             : {"R5 write word kept ", tag}, 64'(v), 64'(expd));
        reg_write(2'd2, 32'h0080_0000);
        reg_read(2'd2, v);
        check(v[23] === 1'b0, {"R8 event cleared ", tag}, 64'(v), 64'h0);
    endtask

    // PHY model: drive turnaround low and the reply after each falling edge.
    initial begin
        forever begin
            @(negedge mdc);
            fall_cnt++;
            phy_drv = 1'b0;
            if (phy_en && cur_rd) begin
                if (fall_cnt == 47) begin
                    phy_drv = 1'b1; phy_val = 1'b0;
                end else if (fall_cnt >= 48 && fall_cnt <= 63) begin
                    phy_drv = 1'b1; phy_val = phy_reply[63 - fall_cnt];
                end
            end
        end
    end

    // Monitor: collect line bits at rising MDC and compare with scoreboard.
    initial begin
        forever begin
            @(posedge mdc);
            t_rise = $time;
            #1;
            held_o = mdio_o; held_oe = mdio_oe; held_ok = 1;
            if (exp_q.size() != 0) begin
                cap_line[63 - bitpos] = mdio_i;
                if (mdio_oe !== !(exp_q[0].rd && bitpos >= 47)) oe_bad = 1;
                bitpos++;
                if (bitpos == 64) begin
                    item_t it;
                    it = exp_q.pop_front();
                    check(cap_line === it.line, "R1 frame on line", cap_line, it.line);
                    check(!oe_bad, "R4 output enable pattern", 64'(oe_bad), 64'h0);
                    bitpos = 0; oe_bad = 0;
                end
            end
        end
    end

    // MDC high time measurement.
    initial begin
        forever begin
            @(negedge mdc);
            high_ns = $time - t_rise;
            held_ok = 0;
        end
    end

    // R2 bench side: line must not move while MDC is high.
    always @(negedge clk) begin
        if (mdc && held_ok && (mdio_o !== held_o || mdio_oe !== held_oe)) r2_bad = 1;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R11 reset state
        reg_read(2'd0, v);
        check(v === 32'h0, "R11 data after reset", 64'(v), 64'h0);
        reg_read(2'd2, v);
        check(v === 32'h0 && mdc === 1'b0 && mdio_oe === 1'b0, "R11 mdc/oe/event after reset",
              {mdc, mdio_oe, v}, 64'h0);

        // speed field 1 (register value 2)
        reg_write(2'd1, 32'd2);
        reg_read(2'd1, v);
        check(v === 32'd2, "R3 speed register readback", 64'(v), 64'd2);

        check(mk_word(1, 0, 0, 0) === 32'h6002_0000, "R1 read base word", 64'(mk_word(1,0,0,0)), 64'h6002_0000);

        run_frame(1, 5'd5, 5'd2, 16'h0000, 1, 16'h1234, "rd5");
        check(high_ns == 10, "R3 mdc high time F=1", 64'(high_ns), 64'd10);
        run_frame(0, 5'd31, 5'd0, 16'hA5C3, 1, 16'h0000, "wr31");
        run_frame(1, 5'd9, 5'd1, 16'h0000, 0, 16'h0000, "absent");

        // speed field 3
        reg_write(2'd1, 32'd6);
        run_frame(1, 5'd1, 5'd3, 16'h0000, 1, 16'h8001, "rd_f3");
        check(high_ns == 30, "R3 mdc high time F=3", 64'(high_ns), 64'd30);

        // R8 writing zero leaves event set
        begin
            item_t it;
            logic [31:0] w;
            w = mk_word(0, 5'd2, 5'd4, 16'h0F0F);
            it.rd = 0; it.line = {32'hFFFF_FFFF, w};
            exp_q.push_back(it);
            cur_rd = 0; fall_cnt = 0;
            reg_write(2'd0, w);
            // R9 write while busy ignored
            reg_write(2'd0, mk_word(1, 5'd7, 5'd7, 16'h1111));
            reg_read(2'd0, v);
            check(v === w, "R9 busy data write ignored", 64'(v), 64'(w));
            wait_event();
            reg_write(2'd2, 32'h0000_0000);
            reg_read(2'd2, v);
            check(v[23] === 1'b1, "R8 write zero keeps event", 64'(v), 64'h0080_0000);
            reg_write(2'd2, 32'h0080_0000);
        end

        // R10 zero speed stalls the frame, nonzero resumes it
        begin
            item_t it;
            logic [31:0] w;
            reg_write(2'd1, 32'd0);
            w = mk_word(0, 5'd3, 5'd5, 16'h5AA5);
            it.rd = 0; it.line = {32'hFFFF_FFFF, w};
            exp_q.push_back(it);
            cur_rd = 0; fall_cnt = 0;
            reg_write(2'd0, w);
            repeat (200) @(negedge clk);
            reg_read(2'd2, v);
            check(mdc === 1'b0 && v[23] === 1'b0, "R10 stalled at zero speed",
                  {mdc, v}, 64'h0);
            reg_write(2'd1, 32'd2);
            wait_event();
            reg_read(2'd2, v);
            check(v[23] === 1'b1, "R10 frame resumed and ended", 64'(v), 64'h0080_0000);
        end

        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R1 all frames observed", 64'(exp_q.size()), 64'h0);
        check(!r2_bad, "R2 line stable while mdc high", 64'(r2_bad), 64'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule